// File: doc/BRIEF.md
# Debug Trigger Match and Chain Unit

The block keeps ten hardware debug triggers and, every cycle, compares them against the current fetch PC and the current load and store addresses. Each trigger is bound to one access class. Triggers are grouped in fixed pairs, and a pair can be chained so that it fires only when both of its halves agree. The block reports which triggers fired, a combined hit, a combined action bit, and a resolved timing. The timing tells the pipeline whether to trap before the instruction (0) or after it (1).

Configuration is written one trigger at a time through a single write port. A flag on the port selects either the fetch trigger space or the memory trigger space. An index picks the trigger within that space. All outputs are combinational from the registered configuration and the current access inputs, so a written configuration first affects the outputs in the cycle after the write.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset every trigger is disabled and every chain bit is clear, so `trig_fire` is 0, `trig_hit` is 0, `trig_action` is 0 and `trig_timing` is 1 for any access inputs.
- R2: A write with `wr_vld`=1 updates one trigger, and the new value is seen by the outputs only from the next cycle. The trigger is chosen as follows.
  - With `wr_mem`=0, `wr_idx` 0..3 selects trigger 0, 1, 6 or 8, and indices 4..7 are ignored.
  - With `wr_mem`=1, `wr_idx` 0..5 selects trigger 2, 3, 4, 5, 7 or 9, and indices 6 and 7 are ignored.
- R3: Each trigger compares against one access class, and only while that class's valid input is high.
  - Triggers 0, 1, 6 and 8 use `fetch_pc` and `fetch_vld`.
  - Triggers 2, 3 and 7 use `store_addr` and `store_vld`.
  - Triggers 4, 5 and 9 use `load_addr` and `load_vld`.
- R4: The match type sets the comparison against the compare value, and all comparisons are unsigned.
  - 0: the address is equal to the compare value.
  - 1: the trigger never matches.
  - 2: the address is greater than or equal to the compare value.
  - 3: the address is less than the compare value.
  - A trigger with its enable clear, or with its select bit set, never matches.
- R5: Pair i is made of triggers 2i and 2i+1. Its chain bit is written only by a write to trigger 2i; the chain bit of a write to trigger 2i+1 is ignored. A chained pair fires both triggers only when both match with equal timing bits; otherwise neither fires.
- R6: Pair 1 (the store/store pair, triggers 2 and 3) never fires while chained.
- R7: In a pair that is not chained, each trigger fires exactly when it matches.
- R8: `trig_fire[k]` shows whether trigger k fired, and `trig_hit` is the OR of all bits of `trig_fire`.
- R9: `trig_timing` is 1 only if every fired trigger has timing bit 1. A trigger that did not fire counts as 1.
- R10: `trig_action` is 1 when at least one fired trigger has its action bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_vld | input | 1 | Configuration write strobe |
| wr_mem | input | 1 | 0: fetch trigger space, 1: memory trigger space |
| wr_idx | input | 3 | Trigger index within the selected space |
| wr_mtype | input | 2 | Match type |
| wr_sel | input | 1 | Data-value select (set means the trigger never matches) |
| wr_timing | input | 1 | 0 = trap before, 1 = trap after |
| wr_action | input | 1 | Action bit |
| wr_chain | input | 1 | Chain bit (used on even triggers only) |
| wr_en | input | 1 | Trigger enable |
| wr_cmp | input | AW | Compare value |
| fetch_vld | input | 1 | Fetch access valid |
| fetch_pc | input | AW | Fetch PC |
| load_vld | input | 1 | Load access valid |
| load_addr | input | AW | Load address |
| store_vld | input | 1 | Store access valid |
| store_addr | input | AW | Store address |
| trig_fire | output | 10 | Per-trigger fire vector |
| trig_hit | output | 1 | Any trigger fired |
| trig_timing | output | 1 | Merged timing |
| trig_action | output | 1 | Merged action |

## Verification
A corrupted trigger register would show up at `trig_fire` in the first cycle in which an access of that trigger's class reaches the compare value. A wrong write decode would show up in the same way: a trigger that fires when it should not, or one that stays silent. A stale or misrouted chain bit would show up as a pair that fires alone when it should stay quiet, or that stays quiet when it should fire. Timing and action errors appear in the same cycle as the hit, so every check samples the combinational outputs in the cycle in which its access is driven.

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_vld,
  input  logic          wr_mem,
  input  logic [2:0]    wr_idx,
  input  logic [1:0]    wr_mtype,
  input  logic          wr_sel,
  input  logic          wr_timing,
  input  logic          wr_action,
  input  logic          wr_chain,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_cmp,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_pc,
  input  logic          load_vld,
  input  logic [AW-1:0] load_addr,
  input  logic          store_vld,
  input  logic [AW-1:0] store_addr,
  output logic [9:0]    trig_fire,
  output logic          trig_hit,
  output logic          trig_timing,
  output logic          trig_action
);
  localparam int NT = 10;
  localparam int NP = NT / 2;
  localparam int ST_PAIR = 1;
  localparam logic [1:0] CL_F = 2'd0, CL_L = 2'd1, CL_S = 2'd2;

  function automatic logic [1:0] cls_of(input int k);
    case (k)
      0, 1, 6, 8: return CL_F;
      2, 3, 7:    return CL_S;
      default:    return CL_L;
    endcase
  endfunction

  logic [NT-1:0] en_q, sel_q, tm_q, act_q, raw;
  logic [1:0]    mt_q  [NT];
  logic [AW-1:0] cmp_q [NT];
  logic [NP-1:0] chain_q;

  logic       tgt_ok;
  logic [3:0] tgt;

  always_comb begin
    tgt    = 4'd0;
    tgt_ok = 1'b0;
    if (!wr_mem) begin
      tgt_ok = !wr_idx[2];
      case (wr_idx[1:0])
        2'd0: tgt = 4'd0;
        2'd1: tgt = 4'd1;
        2'd2: tgt = 4'd6;
        default: tgt = 4'd8;
      endcase
    end else begin
      tgt_ok = (wr_idx < 3'd6);
      case (wr_idx)
        3'd0: tgt = 4'd2;
        3'd1: tgt = 4'd3;
        3'd2: tgt = 4'd4;
        3'd3: tgt = 4'd5;
        3'd4: tgt = 4'd7;
        default: tgt = 4'd9;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      sel_q   <= '0;
      tm_q    <= '0;
      act_q   <= '0;
      chain_q <= '0;
      for (int k = 0; k < NT; k++) begin
        mt_q[k]  <= '0;
        cmp_q[k] <= '0;
      end
    end else if (wr_vld && tgt_ok) begin
      en_q[tgt]  <= wr_en;
      sel_q[tgt] <= wr_sel;
      tm_q[tgt]  <= wr_timing;
      act_q[tgt] <= wr_action;
      mt_q[tgt]  <= wr_mtype;
      cmp_q[tgt] <= wr_cmp;
      if (!tgt[0]) chain_q[tgt[3:1]] <= wr_chain;
    end
  end

  for (genvar k = 0; k < NT; k++) begin : g_cmp
    localparam logic [1:0] C = cls_of(k);
    logic [AW-1:0] a;
    logic          v, m;
    assign a = (C == CL_F) ? fetch_pc  : (C == CL_L) ? load_addr : store_addr;
    assign v = (C == CL_F) ? fetch_vld : (C == CL_L) ? load_vld  : store_vld;
    always_comb begin
      case (mt_q[k])
        2'd0:    m = (a == cmp_q[k]);
        2'd2:    m = (a >= cmp_q[k]);
        2'd3:    m = (a <  cmp_q[k]);
        default: m = 1'b0;
      endcase
    end
    assign raw[k] = en_q[k] && !sel_q[k] && v && m;
  end

  for (genvar i = 0; i < NP; i++) begin : g_pair
    logic both;
    assign both = raw[2*i] && raw[2*i+1] && (tm_q[2*i] == tm_q[2*i+1]);
    if (i == ST_PAIR) begin : g_st
      assign trig_fire[2*i+1:2*i] = chain_q[i] ? 2'b00 : raw[2*i+1:2*i];
      p_store_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q[i] |-> (trig_fire[2*i+1:2*i] == 2'b00));
    end else begin : g_gen
      assign trig_fire[2*i+1:2*i] = chain_q[i] ? {both, both} : raw[2*i+1:2*i];
      p_chain_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q[i] |-> (trig_fire[2*i] == trig_fire[2*i+1]));
    end
  end

  assign trig_hit    = |trig_fire;
  assign trig_timing = &(~trig_fire | tm_q);
  assign trig_action = |(trig_fire & act_q);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (trig_fire == '0));
  p_idle_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_hit |-> trig_timing);
  p_action_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_action |-> trig_hit);
  p_write_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && !wr_mem && wr_idx == 3'd0) |=> (en_q[0] == $past(wr_en)));
endmodule

// File: tb/dbg_trig_unit_tb.sv
module dbg_trig_unit_tb_top;
  localparam int AW = 64;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic          wr_vld = 0, wr_mem = 0, wr_sel = 0, wr_timing = 0, wr_action = 0, wr_chain = 0, wr_en = 0;
  logic [2:0]    wr_idx = 0;
  logic [1:0]    wr_mtype = 0;
  logic [AW-1:0] wr_cmp = 0;
  logic          fetch_vld = 0, load_vld = 0, store_vld = 0;
  logic [AW-1:0] fetch_pc = 0, load_addr = 0, store_addr = 0;
  logic [9:0]    trig_fire;
  logic          trig_hit, trig_timing, trig_action;

  dbg_trig_unit #(.AW(AW)) dut_i (.*);

  typedef struct { logic [9:0] fire; logic hit, tm, act; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic       m_en[10], m_sel[10], m_tm[10], m_act[10];
  logic [1:0] m_mt[10];
  logic [AW-1:0] m_cmp[10];
  logic       m_ch[5];

  function automatic int map_idx(logic mem, logic [2:0] idx);
    if (!mem) begin
      case (idx)
        3'd0: return 0; 3'd1: return 1; 3'd2: return 6; 3'd3: return 8;
        default: return -1;
      endcase
    end
    case (idx)
      3'd0: return 2; 3'd1: return 3; 3'd2: return 4;
      3'd3: return 5; 3'd4: return 7; 3'd5: return 9;
      default: return -1;
    endcase
  endfunction

  function automatic exp_t model(string tag);
    exp_t e;
    logic r[10];
    e.tag = tag;
    e.fire = '0;
    for (int k = 0; k < 10; k++) begin
      logic v, mm;
      logic [AW-1:0] a;
      if (k == 0 || k == 1 || k == 6 || k == 8) begin v = fetch_vld; a = fetch_pc; end
      else if (k == 2 || k == 3 || k == 7)     begin v = store_vld; a = store_addr; end
      else                                      begin v = load_vld;  a = load_addr; end
      case (m_mt[k])
        2'd0: mm = (a == m_cmp[k]);
        2'd2: mm = (a >= m_cmp[k]);
        2'd3: mm = (a < m_cmp[k]);
        default: mm = 0;
      endcase
      r[k] = m_en[k] && !m_sel[k] && v && mm;
    end
    for (int i = 0; i < 5; i++) begin
      if (m_ch[i]) begin
        logic b;
        b = (i != 1) && r[2*i] && r[2*i+1] && (m_tm[2*i] == m_tm[2*i+1]);
        e.fire[2*i] = b; e.fire[2*i+1] = b;
      end else begin
        e.fire[2*i] = r[2*i]; e.fire[2*i+1] = r[2*i+1];
      end
    end
    e.hit = |e.fire;
    e.tm = 1; e.act = 0;
    for (int k = 0; k < 10; k++) if (e.fire[k]) begin
      e.tm = e.tm & m_tm[k];
      e.act = e.act | m_act[k];
    end
    return e;
  endfunction

  // staged stimulus
  logic s_wv = 0, s_wm = 0, s_sel = 0, s_tm = 0, s_act = 0, s_ch = 0, s_en = 0;
  logic [2:0] s_idx = 0;
  logic [1:0] s_mt = 0;
  logic [AW-1:0] s_cmp = 0;
  logic s_fv = 0, s_lv = 0, s_sv = 0;
  logic [AW-1:0] s_pc = 0, s_la = 0, s_sa = 0;

  task automatic cyc(string tag);
    @(posedge clk); #1;
    wr_vld = s_wv; wr_mem = s_wm; wr_idx = s_idx; wr_mtype = s_mt; wr_sel = s_sel;
    wr_timing = s_tm; wr_action = s_act; wr_chain = s_ch; wr_en = s_en; wr_cmp = s_cmp;
    fetch_vld = s_fv; fetch_pc = s_pc; load_vld = s_lv; load_addr = s_la;
    store_vld = s_sv; store_addr = s_sa;
    q.push_back(model(tag));
    if (s_wv) begin
      int t;
      t = map_idx(s_wm, s_idx);
      if (t >= 0) begin
        m_en[t] = s_en; m_sel[t] = s_sel; m_tm[t] = s_tm; m_act[t] = s_act;
        m_mt[t] = s_mt; m_cmp[t] = s_cmp;
        if (t % 2 == 0) m_ch[t/2] = s_ch;
      end
    end
    s_wv = 0;
  endtask

  task automatic wr(logic mem, logic [2:0] idx, logic en, logic [1:0] mt, logic [AW-1:0] cmp,
                    logic tm, logic act, logic ch, logic sel, string tag);
    s_wv = 1; s_wm = mem; s_idx = idx; s_en = en; s_mt = mt; s_cmp = cmp;
    s_tm = tm; s_act = act; s_ch = ch; s_sel = sel;
    cyc(tag);
  endtask

  task automatic acc(logic fv, logic [AW-1:0] pc, logic lv, logic [AW-1:0] la,
                     logic sv, logic [AW-1:0] sa, string tag);
    s_fv = fv; s_pc = pc; s_lv = lv; s_la = la; s_sv = sv; s_sa = sa;
    cyc(tag);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (trig_fire !== e.fire || trig_hit !== e.hit || trig_timing !== e.tm || trig_action !== e.act) begin
        fails++;
        $display("FAIL %s: fire=%h hit=%b tm=%b act=%b expected fire=%h hit=%b tm=%b act=%b",
                 e.tag, trig_fire, trig_hit, trig_timing, trig_action, e.fire, e.hit, e.tm, e.act);
      end
    end
  end

  initial begin
    for (int k = 0; k < 10; k++) begin
      m_en[k] = 0; m_sel[k] = 0; m_tm[k] = 0; m_act[k] = 0; m_mt[k] = 0; m_cmp[k] = 0;
    end
    for (int i = 0; i < 5; i++) m_ch[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state with all classes active at address 0
    acc(1, 0, 1, 0, 1, 0, "R1 reset quiet");
    // R2: write takes effect next cycle
    s_pc = 64'h100;
    wr(0, 0, 1, 0, 64'h100, 0, 0, 0, 0, "R2 write cycle old config");
    acc(1, 64'h100, 0, 0, 0, 0, "R2 R4 eq hit after write");
    acc(1, 64'h104, 0, 0, 0, 0, "R4 eq miss");
    acc(0, 64'h100, 0, 0, 0, 0, "R3 fetch valid low");
    acc(0, 0, 1, 64'h100, 1, 64'h100, "R3 other class ignored");
    // R4 load trigger 4 via mem idx 2
    wr(1, 2, 1, 2, 64'h200, 1, 1, 0, 0, "R2 write t4");
    acc(0, 0, 1, 64'h200, 0, 0, "R4 ge equal R10 action");
    acc(0, 0, 1, 64'h1ff, 0, 0, "R4 ge below");
    wr(1, 2, 1, 3, 64'h200, 1, 1, 0, 0, "R2 write t4 lt");
    acc(0, 0, 1, 64'h1ff, 0, 0, "R4 lt hit");
    acc(0, 0, 1, 64'h200, 0, 0, "R4 lt miss");
    wr(1, 2, 1, 1, 64'h200, 1, 1, 0, 0, "R2 write t4 type1");
    acc(0, 0, 1, 64'h200, 0, 0, "R4 type1 never");
    wr(1, 2, 1, 2, 64'h200, 1, 0, 0, 1, "R2 write t4 sel");
    acc(0, 0, 1, 64'h300, 0, 0, "R4 select never");
    wr(1, 2, 1, 2, 64'h200, 1, 0, 0, 0, "R2 write t4 ge");
    // R9 timing merge
    acc(1, 64'h100, 1, 64'h250, 0, 0, "R9 mixed timing");
    wr(0, 0, 1, 0, 64'h100, 1, 0, 0, 0, "R2 t0 timing1");
    acc(1, 64'h100, 1, 64'h250, 0, 0, "R9 all after");
    // R5 chain pair 0
    wr(0, 1, 1, 0, 64'h100, 1, 0, 0, 0, "R2 write t1");
    wr(0, 0, 1, 0, 64'h100, 1, 0, 1, 0, "R5 chain t0");
    acc(1, 64'h100, 0, 0, 0, 0, "R5 chained both hit");
    wr(0, 1, 1, 0, 64'h104, 1, 0, 0, 0, "R2 t1 other addr");
    acc(1, 64'h100, 0, 0, 0, 0, "R5 chained one hit");
    wr(0, 1, 1, 0, 64'h100, 0, 0, 0, 0, "R5 t1 odd chain ignored");
    acc(1, 64'h100, 0, 0, 0, 0, "R5 timing mismatch none");
    wr(0, 0, 1, 0, 64'h100, 1, 0, 0, 0, "R7 unchain t0");
    acc(1, 64'h100, 0, 0, 0, 0, "R7 R8 independent pair");
    // R6 store pair
    wr(1, 1, 1, 0, 64'h300, 0, 0, 0, 0, "R2 write t3");
    wr(1, 0, 1, 0, 64'h300, 0, 0, 1, 0, "R6 chain t2");
    acc(0, 0, 0, 0, 1, 64'h300, "R6 store chain never");
    wr(1, 0, 1, 0, 64'h300, 0, 1, 0, 0, "R7 unchain t2");
    acc(0, 0, 0, 0, 1, 64'h300, "R7 store pair free R10");
    // R2 ignored indices
    wr(1, 6, 1, 0, 64'h400, 0, 1, 0, 0, "R2 mem idx6");
    wr(1, 7, 1, 0, 64'h400, 0, 1, 0, 0, "R2 mem idx7");
    wr(0, 4, 1, 0, 64'h400, 0, 1, 1, 0, "R2 fetch idx4");
    acc(1, 64'h400, 1, 64'h400, 1, 64'h400, "R2 ignored writes");
    acc(1, 64'h100, 0, 0, 0, 0, "R2 t0 untouched");
    // pair 4 fetch/load chained
    wr(1, 5, 1, 0, 64'h700, 1, 0, 0, 0, "R2 write t9");
    wr(0, 3, 1, 0, 64'h600, 1, 0, 1, 0, "R5 chain t8");
    acc(1, 64'h600, 1, 64'h700, 0, 0, "R5 fetch load chained");
    acc(1, 64'h600, 0, 64'h700, 0, 0, "R5 chained load absent");
    acc(0, 0, 0, 0, 0, 0, "R8 idle");
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule